// File: doc/BRIEF.md
# Double-Precision to Signed Integer Converter

This block turns a 64-bit binary double into a 64-bit two's-complement integer. The rounding direction comes from a 2-bit mode input. A separate chop input forces truncation whatever the mode says.

Values too large for the integer range do not saturate. The block returns the low 64 bits of the exact integer, which is the modulo result. The only exception is the single exact value -2^63, which is representable and raises no flag.

Subnormal inputs either flush to zero or act as a tiny nonzero magnitude that can round to plus or minus one. The block reports three flags: invalid, integer overflow and inexact. A one-cycle start pulse launches a conversion. Result and flags come back together on the following cycle, marked by a one-cycle done pulse.

Top module: `dbl2int_cvt`

## Requirements
- R1: `done` rises exactly one clock after the cycle in which `start` is sampled high, and is low in any cycle that follows a cycle with `start` low. After reset, `done`, `result` and all flags are 0.
- R2: An operand whose 11-bit exponent field (bits 62:52) is all ones (infinity or NaN) gives result 0 with only `flg_invalid` set.
- R3: An exponent field of 0 gives result 0 and no flags when the fraction is 0, or when `ftz` is 1. With a nonzero fraction and `ftz` at 0, the value acts as a nonzero magnitude below one half. `flg_inexact` is set, and the result is 0 or ±1 according to the rounding rule.
- R4: Let e be the exponent field. When e is at least 1075, the result is the mantissa with its hidden bit restored, shifted left by e-1075 and kept to 64 bits. The result is 0 once the shift is 64 or more. No rounding is applied.
- R5: When e is at least 1086, `flg_intovf` and `flg_inexact` are both set. The one exception is the operand 0xC3E0000000000000 (-2^63), which gives 0x8000000000000000 with no flags.
- R6: When e is below 1075, the integer part is the mantissa shifted right. Any nonzero discarded bits set `flg_inexact`. If the discarded field is wider than 62 bits, it is treated as a lone sticky bit.
- R7: Round to nearest even adds one when the discarded part is above one half. It adds the integer's low bit when the discarded part is exactly one half.
- R8: Mode encoding: 00 nearest even, 01 toward zero, 10 toward +infinity, 11 toward -infinity. Toward +infinity adds one to an inexact positive magnitude. Toward -infinity adds one to an inexact negative magnitude. Toward zero adds nothing.
- R9: With `chop` at 1, the result equals truncation toward zero whatever the value of `rmode`.
- R10: A set sign bit negates the rounded magnitude in 64-bit two's complement, so that wrapped out-of-range values keep the low 64 bits of the exact negative integer.
- R11: `flg_invalid` never appears together with `flg_intovf` or `flg_inexact`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches a conversion of the current inputs |
| operand | input | 64 | Double-precision input value |
| rmode | input | 2 | Rounding mode (00 nearest even, 01 toward zero, 10 up, 11 down) |
| chop | input | 1 | Forces truncation toward zero |
| ftz | input | 1 | Treats subnormal inputs as zero |
| done | output | 1 | One-cycle strobe: result and flags valid |
| result | output | 64 | Two's-complement integer result |
| flg_invalid | output | 1 | Infinity or NaN input |
| flg_intovf | output | 1 | Magnitude outside the signed 64-bit range |
| flg_inexact | output | 1 | Bits were discarded or the value wrapped |

## Verification
The assertions assume that `operand`, `rmode`, `chop` and `ftz` are settled in the cycle where `start` is high, since the converter samples them only then. The exponent-window properties also assume that `start` pulses are separated by at least one idle cycle, so that each `done` can be tied to a single launch. The bench drives one isolated pulse per conversion and holds the inputs steady across it. Random exponents are steered into the bands that matter: specials, subnormals, the rounding region, exact left shifts and the wrap region around 1086. Directed ties and the -2^63 pattern are added on top.

// File: rtl/dbl2int_pkg.sv
package dbl2int_pkg;
  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_UP   = 2'b10,
    RM_DOWN = 2'b11
  } rmode_e;

  typedef struct packed {
    logic inv;
    logic iov;
    logic ine;
  } cvt_flags_t;
endpackage

// File: rtl/dbl2int_align.sv
// Splits the operand, restores the hidden bit and aligns the mantissa
// against the binary point, producing the integer magnitude and a
// left-justified word of discarded bits.
module dbl2int_align #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  parameter int INT_W = 64
) (
  input  logic [EXP_W+MAN_W:0] op,
  input  logic                 ftz,
  output logic                 sign,
  output logic                 special,
  output logic                 ovf,
  output logic [INT_W-1:0]     mag,
  output logic [INT_W-1:0]     rword
);
  localparam int OP_W   = EXP_W + MAN_W + 1;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int OFFS   = BIAS + MAN_W;
  localparam int OVF_SH = INT_W - MAN_W - 1;
  localparam logic [OP_W-1:0] MIN_PAT =
    {1'b1, EXP_W'(BIAS + INT_W - 1), {MAN_W{1'b0}}};

  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] fr;
  logic [INT_W-1:0] ext;
  int               sh;

  assign sign = op[OP_W-1];
  assign ex   = op[OP_W-2 -: EXP_W];
  assign fr   = op[MAN_W-1:0];
  assign ext  = INT_W'({1'b1, fr});

  always_comb begin
    special = 1'b0;
    ovf     = 1'b0;
    mag     = '0;
    rword   = '0;
    sh      = int'(ex) - OFFS;
    if (ex == '0) begin
      // subnormal: only a sticky bit survives unless flushed
      if (fr != '0 && !ftz) rword = INT_W'(1);
    end else if (ex == '1) begin
      special = 1'b1;
    end else if (sh >= 0) begin
      if (sh < INT_W) mag = ext << sh;
      ovf = (sh >= OVF_SH) && (op != MIN_PAT);
    end else if (-sh < INT_W - 1) begin
      mag   = ext >> (-sh);
      rword = ext << (INT_W + sh);
    end else begin
      rword = INT_W'(1);
    end
  end
endmodule

// File: rtl/dbl2int_round.sv
// Applies the rounding increment and the sign.
module dbl2int_round
  import dbl2int_pkg::*;
#(
  parameter int INT_W = 64
) (
  input  rmode_e           mode,
  input  logic             sign,
  input  logic [INT_W-1:0] mag,
  input  logic [INT_W-1:0] rword,
  output logic [INT_W-1:0] res,
  output logic             lost
);
  localparam logic [INT_W-1:0] HALF = {1'b1, {(INT_W-1){1'b0}}};

  logic             inc;
  logic [INT_W-1:0] sum;

  assign lost = (rword != '0);

  always_comb begin
    inc = 1'b0;
    if (lost) begin
      unique case (mode)
        RM_NEAR: inc = (rword == HALF) ? mag[0] : (rword > HALF);
        RM_ZERO: inc = 1'b0;
        RM_UP:   inc = ~sign;
        RM_DOWN: inc = sign;
        default: inc = 1'b0;
      endcase
    end
  end

  assign sum = mag + INT_W'(inc);
  assign res = sign ? (~sum + INT_W'(1)) : sum;
endmodule

// File: rtl/dbl2int_cvt.sv
module dbl2int_cvt
  import dbl2int_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  parameter int INT_W = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [EXP_W+MAN_W:0] operand,
  input  logic [1:0]           rmode,
  input  logic                 chop,
  input  logic                 ftz,
  output logic                 done,
  output logic [INT_W-1:0]     result,
  output logic                 flg_invalid,
  output logic                 flg_intovf,
  output logic                 flg_inexact
);
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int OFFS   = BIAS + MAN_W;
  localparam int WRAP_E = OFFS + INT_W - MAN_W - 1;
  localparam int OP_W   = EXP_W + MAN_W + 1;

  rmode_e           mode_eff;
  logic             a_sign, a_special, a_ovf, r_lost;
  logic [INT_W-1:0] a_mag, a_rword, r_res;
  cvt_flags_t       nxt_flags, flags_q;

  assign mode_eff = chop ? RM_ZERO : rmode_e'(rmode);

  dbl2int_align #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_align (
    .op(operand), .ftz(ftz), .sign(a_sign), .special(a_special),
    .ovf(a_ovf), .mag(a_mag), .rword(a_rword)
  );

  dbl2int_round #(.INT_W(INT_W)) u_round (
    .mode(mode_eff), .sign(a_sign), .mag(a_mag), .rword(a_rword),
    .res(r_res), .lost(r_lost)
  );

  always_comb begin
    nxt_flags.inv = a_special;
    nxt_flags.iov = a_ovf;
    nxt_flags.ine = a_ovf | r_lost;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done    <= 1'b0;
      result  <= '0;
      flags_q <= '0;
    end else begin
      done <= start;
      if (start) begin
        result  <= r_res;
        flags_q <= nxt_flags;
      end
    end
  end

  assign flg_invalid = flags_q.inv;
  assign flg_intovf  = flags_q.iov;
  assign flg_inexact = flags_q.ine;

  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    start |=> done); // R1
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !start |=> !done); // R1
  AST_SPECIAL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (start && operand[OP_W-2 -: EXP_W] == '1)
      |=> (flg_invalid && result == '0 && !flg_inexact)); // R2
  AST_EXACT_LEFT: assert property (@(posedge clk) disable iff (rst)
    (start && int'(operand[OP_W-2 -: EXP_W]) >= OFFS
           && int'(operand[OP_W-2 -: EXP_W]) < WRAP_E)
      |=> (!flg_inexact && !flg_intovf)); // R4
  AST_OVF_INEXACT: assert property (@(posedge clk) disable iff (rst)
    (done && flg_intovf) |-> flg_inexact); // R5
  AST_INV_ALONE: assert property (@(posedge clk) disable iff (rst)
    flg_invalid |-> (!flg_intovf && !flg_inexact)); // R11
endmodule

// File: tb/dbl2int_cvt_bench.sv
module dbl2int_cvt_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [63:0] operand = '0;
  logic [1:0]  rmode = '0;
  logic        chop = 1'b0;
  logic        ftz = 1'b0;
  logic        done;
  logic [63:0] result;
  logic        flg_invalid, flg_intovf, flg_inexact;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  dbl2int_cvt u_dbl2int_cvt (
    .clk(clk), .rst(rst), .start(start), .operand(operand), .rmode(rmode),
    .chop(chop), .ftz(ftz), .done(done), .result(result),
    .flg_invalid(flg_invalid), .flg_intovf(flg_intovf),
    .flg_inexact(flg_inexact)
  );

  // expected {inv, iov, ine, result}
  function automatic logic [66:0] model(logic [63:0] a, logic [1:0] m,
                                        logic c, logic f);
    logic        s = a[63];
    int          e = int'(a[62:52]);
    logic [63:0] man = {11'd0, 1'b1, a[51:0]};
    logic [63:0] r = '0;
    logic [63:0] rw = '0;
    logic        inv = 0, iov = 0, ine = 0;
    int          sh = e - 1075;
    logic [1:0]  md = c ? 2'b01 : m;
    if (e == 0) begin
      if (a[51:0] != 0 && !f) rw = 64'd1;
    end else if (e == 2047) begin
      inv = 1;
    end else if (sh >= 0) begin
      if (sh < 64) r = man << sh;
      if (sh >= 11 && a != 64'hC3E0000000000000) begin iov = 1; ine = 1; end
    end else if (-sh < 63) begin
      r  = man >> (-sh);
      rw = man << (64 + sh);
    end else rw = 64'd1;
    if (rw != 0) begin
      ine = 1;
      case (md)
        2'b00: if (rw == 64'h8000000000000000) r = r + {63'd0, r[0]};
               else if (rw > 64'h8000000000000000) r = r + 1;
        2'b10: if (!s) r = r + 1;
        2'b11: if (s) r = r + 1;
        default: ;
      endcase
    end
    if (s) r = -r;
    return {inv, iov, ine, r};
  endfunction

  task automatic chk(string tag, logic [66:0] got, logic [66:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic conv(string tag, logic [63:0] a, logic [1:0] m,
                      logic c, logic f);
    operand = a; rmode = m; chop = c; ftz = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R1 done"}, {66'd0, done}, 67'd1);
    chk(tag, {flg_invalid, flg_intovf, flg_inexact, result}, model(a, m, c, f));
    @(negedge clk);
    chk({tag, " R1 pulse"}, {66'd0, done}, 67'd0);
  endtask

  task automatic conv_lit(string tag, logic [63:0] a, logic [1:0] m,
                          logic c, logic f, logic [2:0] fl, logic [63:0] r);
    conv(tag, a, m, c, f);
    chk({tag, " literal"}, {flg_invalid, flg_intovf, flg_inexact, result},
        {fl, r});
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] a;
    int          e;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset", {done, flg_invalid, flg_intovf, flg_inexact, result}, 68'd0);

    conv_lit("R2 inf",       64'h7FF0000000000000, 2'b00, 0, 0, 3'b100, 64'd0);
    conv_lit("R2 nan",       64'hFFF8000000000001, 2'b10, 0, 0, 3'b100, 64'd0);
    conv_lit("R3 zero",      64'h8000000000000000, 2'b10, 0, 0, 3'b000, 64'd0);
    conv_lit("R3 sub up",    64'h0000000000000001, 2'b10, 0, 0, 3'b001, 64'd1);
    conv_lit("R3 sub ftz",   64'h0000000000000001, 2'b10, 0, 1, 3'b000, 64'd0);
    conv_lit("R3 nsub down", 64'h8000000000000001, 2'b11, 0, 0, 3'b001, '1);
    conv_lit("R4 one",       64'h3FF0000000000000, 2'b00, 0, 0, 3'b000, 64'd1);
    conv_lit("R4 2^53",      64'h4340000000000000, 2'b00, 0, 0, 3'b000, 64'h20000000000000);
    conv_lit("R5 -2^63",     64'hC3E0000000000000, 2'b00, 0, 0, 3'b000, 64'h8000000000000000);
    conv_lit("R5 2^63",      64'h43E0000000000000, 2'b00, 0, 0, 3'b011, 64'h8000000000000000);
    conv_lit("R4 R5 2^64",   64'h43F0000000000000, 2'b00, 0, 0, 3'b011, 64'd0);
    conv_lit("R7 2.5",       64'h4004000000000000, 2'b00, 0, 0, 3'b001, 64'd2);
    conv_lit("R7 3.5",       64'h400C000000000000, 2'b00, 0, 0, 3'b001, 64'd4);
    conv_lit("R7 R10 -1.5",  64'hBFF8000000000000, 2'b00, 0, 0, 3'b001, -64'd2);
    conv_lit("R6 R8 up",     64'h3FF4000000000000, 2'b10, 0, 0, 3'b001, 64'd2);
    conv_lit("R8 down",      64'h3FF4000000000000, 2'b11, 0, 0, 3'b001, 64'd1);
    conv_lit("R8 ndown",     64'hBFF4000000000000, 2'b11, 0, 0, 3'b001, -64'd2);
    conv_lit("R8 nzero",     64'hBFF4000000000000, 2'b01, 0, 0, 3'b001, -64'd1);
    conv_lit("R9 chop",      64'h3FF4000000000000, 2'b10, 1, 0, 3'b001, 64'd1);
    conv_lit("R6 tiny",      64'h3C00000000000000, 2'b10, 0, 0, 3'b001, 64'd1);
    conv_lit("R10 wrap",     64'hC3F0000000000001, 2'b00, 0, 0, 3'b011, 64'hFFFFFFFFFFFFF000);

    for (int i = 0; i < 3000; i++) begin
      a = {$urandom, $urandom};
      case ($urandom_range(0, 9))
        0: e = 2047;
        1: e = 0;
        2, 3: e = int'($urandom_range(1000, 1074));
        4: e = int'($urandom_range(1072, 1075));
        5, 6: e = int'($urandom_range(1075, 1150));
        7: e = int'($urandom_range(1080, 1090));
        8: e = int'(a[62:52]);
        default: e = int'($urandom_range(1018, 1030));
      endcase
      a[62:52] = 11'(e);
      conv("R6 R7 R8 R9 R10 random", a, 2'($urandom_range(0, 3)),
           $urandom_range(0, 7) == 0, 1'($urandom_range(0, 1)));
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule